// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block fetches 16-bit words from a three-wire serial configuration EEPROM. It drives the memory's chip select, shift clock and serial data input, and it samples the memory's serial data output. A host supplies a word address with a one-cycle start request. The block sends a read command frame, then clocks in sixteen data bits and presents the word with a one-cycle done strobe. Each half period of the shift clock lasts a programmable number of system clocks, so the serial clock can be held under the memory's limit.

After reset, an optional built-in sequencer first reads a fixed range of words on its own. From three consecutive words of that image it assembles a 48-bit station address and then flags the address as valid. The host interface reports busy for the whole of that power-up load.

Top module: `eeprom_word_reader`

## Requirements
- R1: A read sends an ADDR_W+5 bit command frame, MSB first: two zero bits, a start bit 1, the opcode bits 1 then 0, then the word address MSB first. Each frame bit is placed on `ee_di` while `ee_sk` is low and is held through the following high half period. `ee_di` never changes while `ee_sk` is high.
- R2: The pins move in steps of HALF_DIV system clocks. After an accepted start, the first step has `ee_cs` low and `ee_sk` low. `ee_cs` is high from the second step until the last data bit has been read. Each frame bit takes one low step followed by one high step.
- R3: After the frame, one step follows with `ee_sk` low and `ee_di` low. Sixteen data bits then follow, MSB first. Each data bit takes one high step and then one low step, and `ee_do` is sampled at the end of the high step. `rdata` returns the sixteen bits in the order they arrive.
- R4: The last step has `ee_cs` low. In the cycle after it ends, `done` is high for exactly one cycle, `busy` is low and `rdata` holds the new word. With ADDR_W=6, a read lasts 57 steps.
- R5: `rdata` changes only in a cycle where `done` is high, and it holds its value across idle time and across later transactions until the next `done`.
- R6: `busy` rises in the cycle after an accepted start. A `start` raised while `busy` is high has no effect on the pins, on `rdata` or on timing.
- R7: While no transaction is running, and during reset, `ee_cs`, `ee_sk`, `ee_di` and `done` are all low.
- R8: With AUTOLOAD=1, the block reads words LOAD_FIRST through LOAD_LAST in ascending order starting right after reset. One idle cycle separates consecutive reads. `busy` is high during reset and for the whole sequence, and host starts made during that time are ignored.
- R9: `station_addr[47:40]` is the low byte of word STA_WORD and `[39:32]` is its high byte. Bits `[31:16]` come from word STA_WORD+1 and bits `[15:0]` from word STA_WORD+2, each with its low byte in the upper half. `station_valid` goes high in the cycle after the last power-up read ends and stays high. `busy` drops in that same cycle.
- R10: After reset, `rdata` and `station_addr` are zero and `station_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle read request, accepted only while `busy` is low |
| word_addr | input | ADDR_W | Word address for the requested read |
| busy | output | 1 | High while a read or the power-up load is in progress |
| done | output | 1 | One-cycle strobe marking a finished host read |
| rdata | output | 16 | Last word read for the host |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | EEPROM shift clock |
| ee_di | output | 1 | Serial data towards the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |
| station_addr | output | 48 | Station address assembled during power-up |
| station_valid | output | 1 | Station address has been loaded |

## Verification
The bench builds the block with HALF_DIV=2, ADDR_W=6 and the power-up load enabled over words 0 to 15, with the station address at word 10. The short half period keeps the complete 16-word power-up load, and the host reads after it, within a few thousand cycles. Every pin can therefore be compared against the model on every clock, including the idle cycle between power-up reads and the moment the station address becomes valid. The 6-bit address lets the bench reach both the all-zero word and the top word 0x3F. It also lets the bench test a start request in the very cycle that `done` is high, and one raised in the middle of a read.

// File: rtl/eerd_pkg.sv
package eerd_pkg;

  localparam int WORD_W = 16;
  localparam int STA_W  = 48;

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_PRE,
    ENG_CMD,
    ENG_GAP,
    ENG_DATA,
    ENG_POST
  } eng_state_t;

  typedef enum logic [1:0] {
    SEQ_LAUNCH,
    SEQ_WAIT,
    SEQ_FINISH
  } seq_state_t;

  typedef struct packed {
    logic cs;
    logic sk;
    logic di;
  } ee_pins_t;

endpackage

// File: rtl/eerd_rst_sync.sv
module eerd_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic s0_q, s1_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign rst_n_o = s1_q;

endmodule

// File: rtl/eerd_halfdiv.sv
module eerd_halfdiv #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (!run)               cnt_n = '0;
    else if (cnt_q == LAST) cnt_n = '0;
    else                    cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/eerd_engine.sv
module eerd_engine
  import eerd_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic              tick,
  input  logic              sdo,
  output logic              busy,
  output logic              cs,
  output logic              sk,
  output logic              di,
  output logic              fin,
  output logic [DATA_W-1:0] word
);

  localparam int CMD_W = ADDR_W + 5;
  localparam int MAXB  = (CMD_W > DATA_W) ? CMD_W : DATA_W;
  localparam int BCW   = $clog2(MAXB);

  eng_state_t        st_q, st_n;
  logic [CMD_W-1:0]  cmd_q, cmd_n;
  logic [DATA_W-1:0] dat_q, dat_n;
  logic [BCW-1:0]    bit_q, bit_n;
  logic              hi_q, hi_n;
  ee_pins_t          pin_q, pin_n;
  logic              upd;

  // frame: pad 00, start 1, read opcode 10, address
  logic [CMD_W-1:0] frame;
  assign frame = {2'b00, 3'b110, addr};

  always_comb begin
    st_n  = st_q;
    cmd_n = cmd_q;
    dat_n = dat_q;
    bit_n = bit_q;
    hi_n  = hi_q;
    pin_n = pin_q;
    fin   = 1'b0;
    case (st_q)
      ENG_IDLE: begin
        if (start) begin
          st_n  = ENG_PRE;
          cmd_n = frame;
          pin_n = '{cs: 1'b0, sk: 1'b0, di: 1'b0};
        end
      end
      ENG_PRE: begin
        if (tick) begin
          st_n  = ENG_CMD;
          bit_n = BCW'(CMD_W - 1);
          hi_n  = 1'b0;
          pin_n = '{cs: 1'b1, sk: 1'b0, di: cmd_q[CMD_W-1]};
        end
      end
      ENG_CMD: begin
        if (tick) begin
          if (!hi_q) begin
            hi_n     = 1'b1;
            pin_n.sk = 1'b1;
          end else if (bit_q == '0) begin
            st_n  = ENG_GAP;
            pin_n = '{cs: 1'b1, sk: 1'b0, di: 1'b0};
          end else begin
            bit_n = bit_q - 1'b1;
            cmd_n = {cmd_q[CMD_W-2:0], 1'b0};
            hi_n  = 1'b0;
            pin_n = '{cs: 1'b1, sk: 1'b0, di: cmd_q[CMD_W-2]};
          end
        end
      end
      ENG_GAP: begin
        if (tick) begin
          st_n  = ENG_DATA;
          hi_n  = 1'b1;
          bit_n = BCW'(DATA_W - 1);
          pin_n = '{cs: 1'b1, sk: 1'b1, di: 1'b0};
        end
      end
      ENG_DATA: begin
        if (tick) begin
          if (hi_q) begin
            dat_n = {dat_q[DATA_W-2:0], sdo};
            hi_n  = 1'b0;
            pin_n = '{cs: 1'b1, sk: 1'b0, di: 1'b0};
          end else if (bit_q == '0) begin
            st_n  = ENG_POST;
            pin_n = '{cs: 1'b0, sk: 1'b0, di: 1'b0};
          end else begin
            bit_n = bit_q - 1'b1;
            hi_n  = 1'b1;
            pin_n = '{cs: 1'b1, sk: 1'b1, di: 1'b0};
          end
        end
      end
      ENG_POST: begin
        if (tick) begin
          st_n = ENG_IDLE;
          fin  = 1'b1;
        end
      end
      default: st_n = ENG_IDLE;
    endcase
  end

  assign upd = tick || (st_q == ENG_IDLE && start);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ENG_IDLE;
      cmd_q <= '0;
      dat_q <= '0;
      bit_q <= '0;
      hi_q  <= 1'b0;
      pin_q <= '0;
    end else if (upd) begin
      st_q  <= st_n;
      cmd_q <= cmd_n;
      dat_q <= dat_n;
      bit_q <= bit_n;
      hi_q  <= hi_n;
      pin_q <= pin_n;
    end
  end

  assign busy = (st_q != ENG_IDLE);
  assign cs   = pin_q.cs;
  assign sk   = pin_q.sk;
  assign di   = pin_q.di;
  assign word = dat_q;

  AST_DI_HELD_SK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sk && $past(sk)) |-> (di == $past(di)));  // R1
  AST_DI_SET_BEFORE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sk) |-> $stable(di));  // R1
  AST_PINS_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_IDLE) |-> (!cs && !sk && !di));  // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ENG_IDLE && !tick) |=> ($stable(st_q) && $stable(bit_q) && $stable(hi_q)));  // R6
  AST_CS_LOW_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (!cs && !sk));  // R4

endmodule

// File: rtl/eerd_autoload.sv
module eerd_autoload
  import eerd_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int LOAD_FIRST = 0,
  parameter int LOAD_LAST  = 15,
  parameter int STA_WORD   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fin,
  input  logic [WORD_W-1:0] word,
  output logic              launch,
  output logic [ADDR_W-1:0] addr,
  output logic              active,
  output logic [STA_W-1:0]  station,
  output logic              sta_valid
);

  localparam int NSLOT = STA_W / WORD_W;

  seq_state_t        st_q, st_n;
  logic [ADDR_W-1:0] idx_q, idx_n;
  logic [STA_W-1:0]  sta_q, sta_n;
  logic [NSLOT-1:0]  slot_hit;
  logic              got;

  assign got = (st_q == SEQ_WAIT) && fin;

  for (genvar j = 0; j < NSLOT; j++) begin : g_slot
    assign slot_hit[j] = got && (idx_q == ADDR_W'(STA_WORD + j));
  end

  always_comb begin
    st_n  = st_q;
    idx_n = idx_q;
    case (st_q)
      SEQ_LAUNCH: st_n = SEQ_WAIT;
      SEQ_WAIT: begin
        if (fin) begin
          if (idx_q == ADDR_W'(LOAD_LAST)) begin
            st_n = SEQ_FINISH;
          end else begin
            st_n  = SEQ_LAUNCH;
            idx_n = idx_q + 1'b1;
          end
        end
      end
      default: st_n = SEQ_FINISH;
    endcase
  end

  // byte 2k of the image is the low byte of word k and goes out first
  always_comb begin
    sta_n = sta_q;
    for (int j = 0; j < NSLOT; j++) begin
      if (slot_hit[j]) sta_n[STA_W-1-WORD_W*j -: WORD_W] = {word[7:0], word[15:8]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_LAUNCH;
      idx_q <= ADDR_W'(LOAD_FIRST);
      sta_q <= '0;
    end else begin
      st_q  <= st_n;
      idx_q <= idx_n;
      if (got) sta_q <= sta_n;
    end
  end

  assign launch    = (st_q == SEQ_LAUNCH);
  assign addr      = idx_q;
  assign active    = (st_q != SEQ_FINISH);
  assign station   = sta_q;
  assign sta_valid = (st_q == SEQ_FINISH);

  AST_STA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sta_valid) |-> sta_valid);  // R9
  AST_LOAD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (idx_q >= ADDR_W'(LOAD_FIRST) && idx_q <= ADDR_W'(LOAD_LAST)));  // R8
  AST_STATION_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    sta_valid |-> $stable(sta_q));  // R9

endmodule

// File: rtl/eeprom_word_reader.sv
module eeprom_word_reader
  import eerd_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int HALF_DIV   = 4,
  parameter bit AUTOLOAD   = 1'b1,
  parameter int LOAD_FIRST = 0,
  parameter int LOAD_LAST  = 15,
  parameter int STA_WORD   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] word_addr,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rdata,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do,
  output logic [STA_W-1:0]  station_addr,
  output logic              station_valid
);

  logic              rst_i;
  logic              tick;
  logic              eng_busy, eng_fin, eng_start;
  logic [ADDR_W-1:0] eng_addr;
  logic [WORD_W-1:0] eng_word;
  logic              seq_launch, seq_active;
  logic [ADDR_W-1:0] seq_addr;
  logic              host_go;
  logic              own_q, own_n;
  logic              done_q, done_n;
  logic [WORD_W-1:0] rd_q, rd_n;

  eerd_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_i)
  );

  eerd_halfdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_i),
    .run   (eng_busy),
    .tick  (tick)
  );

  eerd_engine #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_eng (
    .clk   (clk),
    .rst_n (rst_i),
    .start (eng_start),
    .addr  (eng_addr),
    .tick  (tick),
    .sdo   (ee_do),
    .busy  (eng_busy),
    .cs    (ee_cs),
    .sk    (ee_sk),
    .di    (ee_di),
    .fin   (eng_fin),
    .word  (eng_word)
  );

  if (AUTOLOAD) begin : g_load
    eerd_autoload #(
      .ADDR_W     (ADDR_W),
      .LOAD_FIRST (LOAD_FIRST),
      .LOAD_LAST  (LOAD_LAST),
      .STA_WORD   (STA_WORD)
    ) u_seq (
      .clk       (clk),
      .rst_n     (rst_i),
      .fin       (eng_fin),
      .word      (eng_word),
      .launch    (seq_launch),
      .addr      (seq_addr),
      .active    (seq_active),
      .station   (station_addr),
      .sta_valid (station_valid)
    );
  end else begin : g_noload
    assign seq_launch    = 1'b0;
    assign seq_addr      = '0;
    assign seq_active    = 1'b0;
    assign station_addr  = '0;
    assign station_valid = 1'b0;
  end

  assign busy      = eng_busy || seq_active;
  assign host_go   = start && !busy;
  assign eng_start = seq_launch || host_go;
  assign eng_addr  = seq_launch ? seq_addr : word_addr;

  always_comb begin
    own_n  = own_q;
    done_n = 1'b0;
    rd_n   = rd_q;
    if (host_go) begin
      own_n = 1'b1;
    end else if (eng_fin) begin
      own_n = 1'b0;
      if (own_q) begin
        done_n = 1'b1;
        rd_n   = eng_word;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      own_q  <= 1'b0;
      done_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      own_q  <= own_n;
      done_q <= done_n;
      rd_q   <= rd_n;
    end
  end

  assign done  = done_q;
  assign rdata = rd_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_i)
    done |=> !done);  // R4
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_i)
    done |-> !busy);  // R4
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_i)
    !done |-> $stable(rdata));  // R5
  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0({seq_launch, host_go}));  // R8
  AST_BUSY_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_i)
    host_go |=> busy);  // R6

endmodule

// File: tb/sim_eeprom_word_reader.sv
`timescale 1ns/1ps
module sim_eeprom_word_reader;

  localparam int AW    = 6;
  localparam int HD    = 2;
  localparam int FIRST = 0;
  localparam int LAST  = 15;
  localparam int STAW  = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [AW-1:0] word_addr;
  logic          busy, done;
  logic [15:0]   rdata;
  logic          ee_cs, ee_sk, ee_di;
  logic          ee_do = 1'b0;
  logic [47:0]   station_addr;
  logic          station_valid;

  always #2 clk = ~clk;

  eeprom_word_reader #(
    .ADDR_W(AW), .HALF_DIV(HD), .AUTOLOAD(1'b1),
    .LOAD_FIRST(FIRST), .LOAD_LAST(LAST), .STA_WORD(STAW)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .word_addr(word_addr),
    .busy(busy), .done(done), .rdata(rdata),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do),
    .station_addr(station_addr), .station_valid(station_valid)
  );

  function automatic logic [15:0] romval(input logic [AW-1:0] a);
    return (16'(a) * 16'h2F1B) ^ 16'h6C93 ^ {a, 10'h000};
  endfunction

  // ---------------- EEPROM behavioural model ----------------
  logic          m_started = 1'b0;
  int            m_cnt = 0;
  int            m_dcnt = 0;
  logic [7:0]    m_cmd = '0;
  int            m_badop = 0;
  logic [AW-1:0] seen[$];

  always @(posedge ee_sk or negedge ee_cs) begin
    if (!ee_cs) begin
      m_started = 1'b0;
      m_cnt     = 0;
      m_dcnt    = 0;
      ee_do     = 1'b0;
    end else if (!m_started) begin
      if (ee_di) begin
        m_started = 1'b1;
        m_cnt     = 0;
        m_cmd     = '0;
      end
    end else if (m_cnt < 8) begin
      m_cmd = {m_cmd[6:0], ee_di};
      m_cnt = m_cnt + 1;
      if (m_cnt == 8) begin
        ee_do = 1'b0;
        if (m_cmd[7:6] != 2'b10) m_badop = m_badop + 1;
        seen.push_back(m_cmd[5:0]);
      end
    end else begin
      logic [15:0] w;
      w = romval(m_cmd[5:0]);
      if (m_dcnt < 16) ee_do = w[15 - m_dcnt];
      else             ee_do = 1'b0;
      m_dcnt = m_dcnt + 1;
    end
  end

  // ---------------- reference model ----------------
  typedef struct packed {
    logic        busy;
    logic        cs;
    logic        sk;
    logic        di;
    logic        done;
    logic        stav;
    logic [15:0] rd;
  } exp_t;

  exp_t        q[$];
  int          checks = 0;
  int          errors = 0;
  logic [15:0] exp_rdata;
  bit          finished = 1'b0;

  task automatic fail(input string req, input string what, input int act, input int exp);
    errors++;
    $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
  endtask

  task automatic push_one(input bit b, input bit c, input bit s, input bit d, input bit v);
    exp_t e;
    e = '0;
    e.busy = b; e.cs = c; e.sk = s; e.di = d; e.stav = v;
    q.push_back(e);
  endtask

  task automatic push_step(input bit c, input bit s, input bit d, input bit v);
    for (int k = 0; k < HD; k++) push_one(1'b1, c, s, d, v);
  endtask

  task automatic push_txn(input logic [AW-1:0] a, input bit host, input bit v);
    logic [AW+4:0] fr;
    exp_t e;
    fr = {2'b00, 3'b110, a};
    push_step(1'b0, 1'b0, 1'b0, v);
    for (int i = AW + 4; i >= 0; i--) begin
      push_step(1'b1, 1'b0, fr[i], v);
      push_step(1'b1, 1'b1, fr[i], v);
    end
    push_step(1'b1, 1'b0, 1'b0, v);
    for (int i = 0; i < 16; i++) begin
      push_step(1'b1, 1'b1, 1'b0, v);
      push_step(1'b1, 1'b0, 1'b0, v);
    end
    push_step(1'b0, 1'b0, 1'b0, v);
    if (host) begin
      e = '0;
      e.done = 1'b1; e.stav = v; e.rd = romval(a);
      q.push_back(e);
    end
  endtask

  task automatic cyc(input bit st, input logic [AW-1:0] a);
    exp_t e;
    @(negedge clk);
    if (q.size() > 0) e = q.pop_front();
    else begin
      e = '0;
      e.stav = 1'b1;
    end
    if (e.done) exp_rdata = e.rd;
    checks++;
    if (done !== e.done)                fail("R4", "done", int'(done), int'(e.done));
    else if (ee_cs !== e.cs)            fail("R2", "ee_cs", int'(ee_cs), int'(e.cs));
    else if (ee_sk !== e.sk)            fail("R2", "ee_sk", int'(ee_sk), int'(e.sk));
    else if (ee_di !== e.di)            fail("R1", "ee_di", int'(ee_di), int'(e.di));
    else if (busy !== e.busy)           fail("R6", "busy", int'(busy), int'(e.busy));
    else if (station_valid !== e.stav)  fail("R9", "station_valid", int'(station_valid), int'(e.stav));
    checks++;
    if (rdata !== exp_rdata) fail(e.done ? "R3" : "R5", "rdata", int'(rdata), int'(exp_rdata));
    start     = st;
    word_addr = a;
    if (st && !e.busy) push_txn(a, 1'b1, 1'b1);
  endtask

  task automatic drain();
    while (q.size() > 0) cyc(1'b0, '0);
  endtask

  task automatic run_to_done_cycle_then(input logic [AW-1:0] a);
    while (q.size() > 1) cyc(1'b0, '0);
    cyc(1'b1, a);  // start issued in the cycle done is high
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [47:0] exp_sta;
    rst_n = 1'b0;
    start = 1'b0;
    word_addr = '0;
    exp_rdata = '0;
    repeat (3) @(negedge clk);

    // reset state
    checks++; if (busy !== 1'b1) fail("R8", "busy in reset", int'(busy), 1);
    checks++; if ({ee_cs, ee_sk, ee_di} !== 3'b000) fail("R7", "pins in reset", int'({ee_cs, ee_sk, ee_di}), 0);
    checks++; if (done !== 1'b0) fail("R7", "done in reset", int'(done), 0);
    checks++; if (station_valid !== 1'b0) fail("R10", "station_valid in reset", int'(station_valid), 0);
    checks++; if (rdata !== 16'h0) fail("R10", "rdata in reset", int'(rdata), 0);
    checks++; if (station_addr !== 48'h0) fail("R10", "station_addr in reset", 1, 0);

    // power-up load expectation (R8)
    for (int w = FIRST; w <= LAST; w++) begin
      push_one(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      push_txn(AW'(w), 1'b0, 1'b0);
    end

    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 300; i++) cyc(1'b0, '0);
    cyc(1'b1, 6'h05);  // R8: ignored during power-up load
    drain();
    repeat (3) cyc(1'b0, '0);

    exp_sta = {romval(STAW)[7:0],   romval(STAW)[15:8],
               romval(STAW+1)[7:0], romval(STAW+1)[15:8],
               romval(STAW+2)[7:0], romval(STAW+2)[15:8]};
    checks++; if (station_addr !== exp_sta) begin
      errors++;
      $display("FAIL R9 station_addr: actual %012h expected %012h", station_addr, exp_sta);
    end
    checks++; if (seen.size() != LAST - FIRST + 1) fail("R8", "power-up read count", seen.size(), LAST - FIRST + 1);
    for (int i = 0; i < seen.size() && i <= LAST - FIRST; i++) begin
      checks++;
      if (seen[i] != AW'(FIRST + i)) fail("R8", "power-up read order", int'(seen[i]), FIRST + i);
    end
    seen.delete();

    // host reads
    cyc(1'b1, 6'h15);                       // R3
    drain();
    repeat (4) cyc(1'b0, '0);               // R5 hold while idle
    cyc(1'b1, 6'h3F);                       // R1 top address
    for (int i = 0; i < 25; i++) cyc(1'b0, '0);
    cyc(1'b1, 6'h2A);                       // R6 ignored mid-read
    cyc(1'b0, '0);
    run_to_done_cycle_then(6'h00);          // R4 restart in done cycle
    run_to_done_cycle_then(6'h07);
    drain();
    repeat (10) cyc(1'b0, '0);              // R5

    checks++; if (rdata !== romval(6'h07)) fail("R3", "final rdata", int'(rdata), int'(romval(6'h07)));
    checks++; if (seen.size() != 4) fail("R6", "host read count", seen.size(), 4);
    if (seen.size() == 4) begin
      checks++; if (seen[0] != 6'h15) fail("R1", "address frame 0", int'(seen[0]), 'h15);
      checks++; if (seen[1] != 6'h3F) fail("R1", "address frame 1", int'(seen[1]), 'h3F);
      checks++; if (seen[2] != 6'h00) fail("R1", "address frame 2", int'(seen[2]), 'h00);
      checks++; if (seen[3] != 6'h07) fail("R1", "address frame 3", int'(seen[3]), 'h07);
    end
    checks++; if (m_badop != 0) fail("R1", "opcode bits", m_badop, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule